// File: doc/BRIEF.md
# Lane-Partitioned 128-bit Integer Vector Adder/Multiplier

This block is a pipelined integer vector unit with one 128-bit datapath. A mode input cuts the datapath into eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Every lane applies the same operation in a given cycle: add, subtract, or multiply keeping the low half of the product. No carry, borrow or partial product crosses from one lane into the next.

A new full-width operation can be presented on every clock. Operands, mode and opcode are captured together. The result and its valid strobe come out a fixed two stages later. Reserved encodings produce a zeroed result with an error flag, so a bad control word is visible at the output and is not silently computed.

Top module: `simd_lane_alu`

## Requirements
- R1: Inputs presented with in_valid high are captured at a rising edge, and out_valid with the matching result and error flag appear after the following rising edge. Operations presented on consecutive cycles each produce their own result on consecutive cycles.
- R2: Mode 2'b00 selects eight 16-bit lanes. Lane k occupies bits [16k+15:16k], so lane 0 is the least significant.
- R3: Mode 2'b01 selects four 32-bit lanes. Lane k occupies bits [32k+31:32k].
- R4: Mode 2'b10 selects two 64-bit lanes. Lane k occupies bits [64k+63:64k].
- R5: Carries from addition and borrows from subtraction stop at every lane boundary of the selected mode. For example, all-ones plus one gives zero in every lane, and zero minus one gives all ones in every lane.
- R6: Opcode 2'b00 adds, 2'b01 subtracts (a minus b) and 2'b10 multiplies. The multiply returns the low lane-width bits of each per-lane product. All results wrap modulo 2 to the power of the lane width.
- R7: Mode 2'b11 or opcode 2'b11 gives an all-zero result with out_err high. Every other valid operation gives out_err low.
- R8: While rst is high at a rising edge, out_valid, result and out_err are cleared to zero.
- R9: After a cycle that captured no valid input, result and out_err keep their previous values and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| mode | input | 2 | Lane width: 00 16-bit, 01 32-bit, 10 64-bit, 11 reserved |
| op | input | 2 | 00 add, 01 subtract, 10 multiply low, 11 reserved |
| a | input | 128 | First operand, lane 0 in the low bits |
| b | input | 128 | Second operand, lane 0 in the low bits |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Lane-wise result |
| out_err | output | 1 | Reserved mode or opcode in the reported operation |

## Verification
A lane boundary cut at the wrong place, or a stale mode held in the capture stage, shows up as one wrong lane two edges after the offending input. Carry-chain corners with all-ones and zero operands make any leaking carry flip the neighbouring lane at once. A stuck or skipped pipeline valid shows as out_valid off by one cycle relative to the input. A result register that updates without a valid input shows on the next idle cycle as a changed output.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              out_err
);
  localparam int N16 = DATA_W / 16;
  localparam int N32 = DATA_W / 32;
  localparam int N64 = DATA_W / 64;

  logic              s1_v;
  logic [1:0]        s1_mode, s1_op;
  logic [DATA_W-1:0] s1_a, s1_b;

  logic [DATA_W-1:0] add16, sub16, mul16;
  logic [DATA_W-1:0] add32, sub32, mul32;
  logic [DATA_W-1:0] add64, sub64, mul64;
  logic [DATA_W-1:0] sel_add, sel_sub, sel_mul, nxt;
  logic              bad;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    if (in_valid) begin
      s1_a    <= a;
      s1_b    <= b;
      s1_mode <= mode;
      s1_op   <= op;
    end
  end

  genvar i;
  for (i = 0; i < N16; i++) begin : g_l16
    assign add16[i*16 +: 16] = s1_a[i*16 +: 16] + s1_b[i*16 +: 16];
    assign sub16[i*16 +: 16] = s1_a[i*16 +: 16] - s1_b[i*16 +: 16];
    assign mul16[i*16 +: 16] = s1_a[i*16 +: 16] * s1_b[i*16 +: 16];
  end
  for (i = 0; i < N32; i++) begin : g_l32
    assign add32[i*32 +: 32] = s1_a[i*32 +: 32] + s1_b[i*32 +: 32];
    assign sub32[i*32 +: 32] = s1_a[i*32 +: 32] - s1_b[i*32 +: 32];
    assign mul32[i*32 +: 32] = s1_a[i*32 +: 32] * s1_b[i*32 +: 32];
  end
  for (i = 0; i < N64; i++) begin : g_l64
    assign add64[i*64 +: 64] = s1_a[i*64 +: 64] + s1_b[i*64 +: 64];
    assign sub64[i*64 +: 64] = s1_a[i*64 +: 64] - s1_b[i*64 +: 64];
    assign mul64[i*64 +: 64] = s1_a[i*64 +: 64] * s1_b[i*64 +: 64];
  end

  assign sel_add = (s1_mode == 2'b00) ? add16 : (s1_mode == 2'b01) ? add32 : add64;
  assign sel_sub = (s1_mode == 2'b00) ? sub16 : (s1_mode == 2'b01) ? sub32 : sub64;
  assign sel_mul = (s1_mode == 2'b00) ? mul16 : (s1_mode == 2'b01) ? mul32 : mul64;
  assign bad     = (s1_mode == 2'b11) || (s1_op == 2'b11);

  always_comb begin
    case (s1_op)
      2'b00:   nxt = sel_add;
      2'b01:   nxt = sel_sub;
      2'b10:   nxt = sel_mul;
      default: nxt = '0;
    endcase
    if (bad) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        result  <= nxt;
        out_err <= bad;
      end
    end
  end

  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_v);
  a_r1_deliver: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> out_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> ($stable(result) && $stable(out_err)));
  a_r7_zero_on_err: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (result == '0));
  a_r7_flag: assert property (@(posedge clk) disable iff (rst)
    (s1_v && (s1_mode == 2'b11 || s1_op == 2'b11)) |=> out_err);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_mode != 2'b11 && s1_op != 2'b11) |=> !out_err);
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && result == '0));
endmodule

// File: tb/test_simd_lane_alu.sv
module test_simd_lane_alu;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, in_valid, out_valid, out_err;
  logic [1:0]   mode, op;
  logic [127:0] a, b, result;

  simd_lane_alu #(.DATA_W(128)) i_simd_lane_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .op(op),
    .a(a), .b(b), .out_valid(out_valid), .result(result), .out_err(out_err)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic         d1_v = 0, d2_v = 0, d1_e = 0, d2_e = 0, hold_e = 0;
  logic [127:0] d1_r = '0, d2_r = '0, hold_r = '0;
  string        d1_t = "R1", d2_t = "R1";

  function automatic logic [127:0] model(logic [127:0] x, logic [127:0] y,
                                         logic [1:0] m, logic [1:0] o);
    logic [127:0] r, msk, p, q, v;
    int w;
    r = '0;
    if (m == 2'b11 || o == 2'b11) return r;
    w = 16 << m;
    msk = (128'd1 << w) - 128'd1;
    for (int k = 0; k < 128 / w; k++) begin
      p = (x >> (k * w)) & msk;
      q = (y >> (k * w)) & msk;
      case (o)
        2'b00:   v = p + q;
        2'b01:   v = p - q;
        default: v = p * q;
      endcase
      r = r | ((v & msk) << (k * w));
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [127:0] x, logic [127:0] y,
                      logic [1:0] m, logic [1:0] o, string tag);
    @(negedge clk);
    chk("R1 out_valid", {127'd0, out_valid}, {127'd0, d2_v});
    if (d2_v) begin
      chk(d2_t, result, d2_r);
      chk("R7 out_err", {127'd0, out_err}, {127'd0, d2_e});
      hold_r = d2_r;
      hold_e = d2_e;
    end else begin
      chk("R9 hold result", result, hold_r);
      chk("R9 hold err", {127'd0, out_err}, {127'd0, hold_e});
    end
    in_valid = v; a = x; b = y; mode = m; op = o;
    d2_v = d1_v; d2_r = d1_r; d2_e = d1_e; d2_t = d1_t;
    d1_v = v; d1_r = model(x, y, m, o); d1_e = (m == 2'b11 || o == 2'b11); d1_t = tag;
  endtask

  function automatic string tag_of(logic [1:0] m, logic [1:0] o);
    if (m == 2'b11 || o == 2'b11) return "R7";
    if (o == 2'b10) return "R6";
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [127:0] ONES = {128{1'b1}};
  localparam logic [127:0] ONE16 = {8{16'h0001}};
  localparam logic [127:0] ONE32 = {4{32'h1}};
  localparam logic [127:0] ONE64 = {2{64'h1}};

  initial begin
    logic [1:0] m, o;
    logic [127:0] x, y;
    void'($urandom(32'h5EED));
    rst = 1; in_valid = 1; mode = 0; op = 0; a = ONES; b = ONES;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", {127'd0, out_valid}, '0);
    chk("R8 reset result", result, '0);
    chk("R8 reset err", {127'd0, out_err}, '0);
    in_valid = 0;
    rst = 0;

    step(1, ONES, ONE16, 2'b00, 2'b00, "R5");
    step(1, ONES, ONE32, 2'b01, 2'b00, "R5");
    step(1, ONES, ONE64, 2'b10, 2'b00, "R5");
    step(1, '0, ONE16, 2'b00, 2'b01, "R5");
    step(1, '0, ONE32, 2'b01, 2'b01, "R5");
    step(1, '0, ONE64, 2'b10, 2'b01, "R5");
    step(1, ONES, ONES, 2'b00, 2'b10, "R6");
    step(1, ONES, ONES, 2'b01, 2'b10, "R6");
    step(1, ONES, ONES, 2'b10, 2'b10, "R6");
    step(1, 128'h0007_0006_0005_0004_0003_0002_0001_0000, ONE16, 2'b00, 2'b00, "R2");
    step(1, 128'h3_00000002_00000001_00000000, ONE32, 2'b01, 2'b01, "R3");
    step(1, {64'd9, 64'd5}, {64'd3, 64'd7}, 2'b10, 2'b10, "R4");
    step(1, ONES, ONES, 2'b11, 2'b00, "R7");
    step(0, ONES, ONES, 2'b00, 2'b00, "R9");
    step(0, ONES, ONES, 2'b00, 2'b00, "R9");
    step(1, ONES, ONE16, 2'b01, 2'b11, "R7");
    step(1, ONES, ONE16, 2'b00, 2'b00, "R7");

    for (int n = 0; n < 400; n++) begin
      m = 2'($urandom % 4);
      o = 2'($urandom % 4);
      x = {$urandom, $urandom, $urandom, $urandom};
      y = {$urandom, $urandom, $urandom, $urandom};
      if (n % 5 == 0) y = ONES;
      step(($urandom % 4) != 0, x, y, m, o, tag_of(m, o));
    end
    step(0, '0, '0, 2'b00, 2'b00, "R9");
    step(0, '0, '0, 2'b00, 2'b00, "R9");
    step(0, '0, '0, 2'b00, 2'b00, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule